// File: doc/BRIEF.md
# Peak-Current Compensation Ramp Generator

This block produces the digital slope-compensation ramp for peak-current-mode power conversion. Whenever an enabled PWM channel signals the start of a new switching frame, the ramp reloads. Its start point is the live output of a chosen control-loop filter, so the peak-current target follows the outer loop from one frame to the next. After the reload the ramp climbs by a programmed step at a fixed interval of clock cycles. It stops at a programmable ceiling, or at full scale when no ceiling is enabled. It never wraps.

On every cycle the ramp is compared with the digitized primary-current sample from one chosen front end. The first time the ramp is above that sample within a frame, the block raises a single-clock peak-detect pulse for the PWM channels. The analog DAC and comparator are modelled as plain digital arithmetic. The step value is computed by software from the wanted slope: step = trunc(335.5 × slope in mV/µs), assuming one step interval of 32 ns.

Firmware can switch the start source at runtime, for example from the voltage filter to the current filter when constant-current operation takes over. The new choice takes effect at the next frame start.

Top module: `pcm_ramp_gen`

## Requirements
- R1: During and after reset, with no frame start yet seen, `rampOut` is 0 and `peakDetect` and `rampActive` are 0.
- R2: At a clock edge where `rampEn` is 1 and some channel i has both `frameStart[i]` and `frameSyncEn[i]` at 1, the ramp reloads. After that edge `rampOut` holds the start value and `rampActive` is 1. A frame start on a channel whose `frameSyncEn` bit is 0 has no effect.
- R3: When `startSrcEn` is 1, the start value is filter slice `filtOut[k*W +: W]`, where k is `filtSel`. A `filtSel` of `NUM_FILT` or more gives 0. When `startSrcEn` is 0, the start value is 0.
- R4: Counting the reload edge as edge 0, after edge e the ramp equals start + floor(e / `STEP_CYCLES`) × `stepVal`, until the limit of R5 is reached.
- R5: The limit is `endVal` when `endEn` is 1, and all ones otherwise. When an advance would pass the limit, the ramp takes the limit value. A ramp that is already at or above the limit holds its value. The ramp never wraps.
- R6: `feSel` picks the sample slice `feSample[j*W +: W]`. Let e be the first edge of the frame after which `rampOut` is strictly greater than that sample. `peakDetect` is 1 after edge e+1. A `feSel` of `NUM_FE` or more never produces a detection.
- R7: `peakDetect` is one clock wide and fires at most once per frame. Each new frame start re-arms it.
- R8: While `rampEn` is 0, `rampOut` is cleared to 0 after the next edge. `rampActive` and `peakDetect` stay 0 and frame starts are ignored.
- R9: Filter values and selections are sampled only at the reload edge. Changing `filtOut` during a frame does not alter the ramp in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rampEn | input | 1 | Ramp enable |
| startSrcEn | input | 1 | Use the filter output as the start value |
| frameStart | input | NUM_CH | Per-channel frame-start strobes |
| frameSyncEn | input | NUM_CH | Per-channel frame-start trigger enables |
| filtSel | input | FSEL_W | Start-source filter select |
| filtOut | input | NUM_FILT*W | Packed loop-filter outputs |
| feSel | input | ESEL_W | Current-sample front-end select |
| feSample | input | NUM_FE*W | Packed primary-current samples |
| stepVal | input | W | Ramp increment per step interval |
| endEn | input | 1 | Enable the end limit |
| endVal | input | W | End limit value |
| rampOut | output | W | Current ramp value |
| rampActive | output | 1 | A frame is in progress |
| peakDetect | output | 1 | Peak-detect pulse |

## Verification
A sweep runs over start values, step sizes, current samples and limit settings. It separates ramps that detect early or late from ramps that never detect. It also separates ramps that saturate at the programmed limit from ramps that saturate at full scale, including starts already above the limit. The non-selected front-end samples are held at values that would give a different detection cycle, so a wrong front-end select shows up. The same holds for the filter inputs and a wrong filter select. Frame starts on masked channels, filter changes in the middle of a frame, out-of-range selects and disable periods are checked separately, to show that each is ignored or gives zero.

// File: rtl/pcm_ramp_pkg.sv
package pcm_ramp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // force ramp to zero
    logic load;     // reload from start source
    logic advance;  // apply one saturating step
  } rampStrobe_t;
endpackage

// File: rtl/pcm_ramp_ctrl.sv
module pcm_ramp_ctrl
  import pcm_ramp_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int STEP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rampEn,
  input  logic [NUM_CH-1:0] frameStart,
  input  logic [NUM_CH-1:0] frameSyncEn,
  input  logic              exceed,
  output rampStrobe_t       strobe,
  output logic              rampActive,
  output logic              peakDetect
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [NUM_CH-1:0] chHit;
  logic              trig;
  logic [CNT_W-1:0]  stepCnt;
  logic              fired;
  logic              fireNow;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign chHit[g] = frameStart[g] & frameSyncEn[g];
  end

  assign trig    = rampEn & (|chHit);
  assign fireNow = rampActive & exceed & ~fired;

  always_comb begin
    strobe.clear   = ~rampEn;
    strobe.load    = trig;
    strobe.advance = rampEn & ~trig & rampActive & (stepCnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rampEn) begin
      rampActive <= 1'b0;
      stepCnt    <= '0;
      fired      <= 1'b0;
      peakDetect <= 1'b0;
    end else if (trig) begin
      rampActive <= 1'b1;
      stepCnt    <= '0;
      fired      <= 1'b0;
      peakDetect <= 1'b0;
    end else begin
      peakDetect <= fireNow;
      if (fireNow) fired <= 1'b1;
      if (rampActive) begin
        if (stepCnt == CNT_LAST) stepCnt <= '0;
        else                     stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_ramp_dp.sv
module pcm_ramp_dp
  import pcm_ramp_pkg::*;
#(
  parameter int W        = 12,
  parameter int NUM_FILT = 3,
  parameter int NUM_FE   = 3,
  parameter int FSEL_W   = 2,
  parameter int ESEL_W   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rampStrobe_t           strobe,
  input  logic                  startSrcEn,
  input  logic [FSEL_W-1:0]     filtSel,
  input  logic [NUM_FILT*W-1:0] filtOut,
  input  logic [ESEL_W-1:0]     feSel,
  input  logic [NUM_FE*W-1:0]   feSample,
  input  logic [W-1:0]          stepVal,
  input  logic                  endEn,
  input  logic [W-1:0]          endVal,
  output logic [W-1:0]          rampOut,
  output logic                  exceed
);
  logic [W-1:0] startVal;
  logic [W-1:0] selSample;
  logic [W-1:0] limit;
  logic [W:0]   sum;
  logic [W-1:0] nextStep;

  always_comb begin
    startVal = '0;
    if (startSrcEn) begin
      for (int i = 0; i < NUM_FILT; i++) begin
        if (filtSel == FSEL_W'(i)) startVal = filtOut[i*W +: W];
      end
    end
  end

  // Out-of-range front-end select yields full scale: never exceeded
  always_comb begin
    selSample = '1;
    for (int j = 0; j < NUM_FE; j++) begin
      if (feSel == ESEL_W'(j)) selSample = feSample[j*W +: W];
    end
  end

  assign limit = endEn ? endVal : '1;
  assign sum   = {1'b0, rampOut} + {1'b0, stepVal};

  always_comb begin
    if (rampOut >= limit)        nextStep = rampOut;
    else if (sum > {1'b0, limit}) nextStep = limit;
    else                          nextStep = sum[W-1:0];
  end

  assign exceed = rampOut > selSample;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) rampOut <= '0;
    else if (strobe.load)      rampOut <= startVal;
    else if (strobe.advance)   rampOut <= nextStep;
  end
endmodule

// File: rtl/pcm_ramp_gen.sv
module pcm_ramp_gen
  import pcm_ramp_pkg::*;
#(
  parameter int W           = 12,
  parameter int NUM_FILT    = 3,
  parameter int NUM_FE      = 3,
  parameter int NUM_CH      = 4,
  parameter int STEP_CYCLES = 4,
  parameter int FSEL_W      = (NUM_FILT > 1) ? $clog2(NUM_FILT + 1) : 1,
  parameter int ESEL_W      = (NUM_FE > 1) ? $clog2(NUM_FE + 1) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rampEn,
  input  logic                  startSrcEn,
  input  logic [NUM_CH-1:0]     frameStart,
  input  logic [NUM_CH-1:0]     frameSyncEn,
  input  logic [FSEL_W-1:0]     filtSel,
  input  logic [NUM_FILT*W-1:0] filtOut,
  input  logic [ESEL_W-1:0]     feSel,
  input  logic [NUM_FE*W-1:0]   feSample,
  input  logic [W-1:0]          stepVal,
  input  logic                  endEn,
  input  logic [W-1:0]          endVal,
  output logic [W-1:0]          rampOut,
  output logic                  rampActive,
  output logic                  peakDetect
);
  rampStrobe_t strobe;
  logic        exceed;

  pcm_ramp_ctrl #(.NUM_CH(NUM_CH), .STEP_CYCLES(STEP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rampEn(rampEn),
    .frameStart(frameStart), .frameSyncEn(frameSyncEn),
    .exceed(exceed), .strobe(strobe),
    .rampActive(rampActive), .peakDetect(peakDetect)
  );

  pcm_ramp_dp #(.W(W), .NUM_FILT(NUM_FILT), .NUM_FE(NUM_FE),
                .FSEL_W(FSEL_W), .ESEL_W(ESEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startSrcEn(startSrcEn), .filtSel(filtSel), .filtOut(filtOut),
    .feSel(feSel), .feSample(feSample), .stepVal(stepVal),
    .endEn(endEn), .endVal(endVal), .rampOut(rampOut), .exceed(exceed)
  );
endmodule

// File: rtl/pcm_ramp_chk.sv
module pcm_ramp_chk #(
  parameter int W      = 12,
  parameter int NUM_FE = 3,
  parameter int NUM_CH = 4,
  parameter int ESEL_W = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                rampEn,
  input logic [NUM_CH-1:0]   frameStart,
  input logic [NUM_CH-1:0]   frameSyncEn,
  input logic [ESEL_W-1:0]   feSel,
  input logic [NUM_FE*W-1:0] feSample,
  input logic [W-1:0]        rampOut,
  input logic                rampActive,
  input logic                peakDetect
);
  logic         trigSeen;
  logic [W-1:0] watchSample;

  assign trigSeen = rampEn & (|(frameStart & frameSyncEn));

  always_comb begin
    watchSample = '1;
    for (int j = 0; j < NUM_FE; j++) begin
      if (feSel == ESEL_W'(j)) watchSample = feSample[j*W +: W];
    end
  end

  // R4 / R5: within a frame the ramp only rises or holds (no wrap)
  p_monotonic_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rampEn && !trigSeen) |=> (rampOut >= $past(rampOut)));

  // R7: detect pulse is one clock wide
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    peakDetect |=> !peakDetect);

  // R6: a detection is preceded by the ramp exceeding the chosen sample
  p_detect_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    peakDetect |-> $past(rampOut > watchSample));

  // R8: disabled block clears and stays silent
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rampEn |=> (rampOut == '0 && !peakDetect && !rampActive));

  // R2: an accepted trigger starts a frame
  p_trigger_r2: assert property (@(posedge clk) disable iff (!rstN)
    trigSeen |=> (rampActive && !peakDetect));
endmodule

bind pcm_ramp_gen pcm_ramp_chk #(.W(W), .NUM_FE(NUM_FE), .NUM_CH(NUM_CH),
                                 .ESEL_W(ESEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .rampEn(rampEn),
  .frameStart(frameStart), .frameSyncEn(frameSyncEn),
  .feSel(feSel), .feSample(feSample),
  .rampOut(rampOut), .rampActive(rampActive), .peakDetect(peakDetect)
);

// File: tb/tb_pcm_ramp_gen.sv
module tb_pcm_ramp_gen;
  localparam int TW = 8;
  localparam int NF = 3;
  localparam int NE = 3;
  localparam int NC = 4;
  localparam int SC = 4;

  logic           clk = 1'b0;
  logic           rstN;
  logic           rampEn, startSrcEn, endEn;
  logic [NC-1:0]  frameStart, frameSyncEn;
  logic [1:0]     filtSel, feSel;
  logic [NF*TW-1:0] filtOut;
  logic [NE*TW-1:0] feSample;
  logic [TW-1:0]  stepVal, endVal;
  logic [TW-1:0]  rampOut;
  logic           rampActive, peakDetect;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pcm_ramp_gen #(.W(TW), .NUM_FILT(NF), .NUM_FE(NE), .NUM_CH(NC),
                 .STEP_CYCLES(SC)) dut (
    .clk(clk), .rstN(rstN), .rampEn(rampEn), .startSrcEn(startSrcEn),
    .frameStart(frameStart), .frameSyncEn(frameSyncEn),
    .filtSel(filtSel), .filtOut(filtOut), .feSel(feSel), .feSample(feSample),
    .stepVal(stepVal), .endEn(endEn), .endVal(endVal),
    .rampOut(rampOut), .rampActive(rampActive), .peakDetect(peakDetect)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rExp(input int st, input int stp, input int lim, input int e);
    int v;
    if (st >= lim) return st;
    v = st + (e / SC) * stp;
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [NF*TW-1:0] packF(input int a, input int b, input int c);
    return {TW'(c), TW'(b), TW'(a)};
  endfunction

  // disturb: 0 none, 1 frame start on channel strayCh at edge 5, 2 change filters at edge 5
  task automatic runFrame(input int ch, input int st, input int stp, input int smp,
                          input bit eEn, input int eVal, input int nEdges,
                          input int disturb, input int strayCh, input string rq);
    int lim, expDet, gotDet, pulses, badE, badAct, badExp;
    lim = eEn ? eVal : (1 << TW) - 1;
    @(negedge clk);
    stepVal = TW'(stp); endEn = eEn; endVal = TW'(eVal);
    frameStart = NC'(1) << ch;
    @(posedge clk);
    @(negedge clk);
    frameStart = '0;
    chk(rampActive == 1'b1, "R2 active after trigger", int'(rampActive), 1);
    expDet = -1;
    for (int e = 0; e < nEdges; e++) begin
      if (rExp(st, stp, lim, e) > smp) begin expDet = e + 1; break; end
    end
    gotDet = -1; pulses = 0; badE = -1; badAct = 0; badExp = 0;
    for (int e = 0; e <= nEdges; e++) begin
      if (e > 0) begin
        if (e == 5 && disturb == 1) frameStart = NC'(1) << strayCh;
        if (e == 5 && disturb == 2) filtOut = packF(250, 251, 252);
        @(posedge clk);
        @(negedge clk);
        frameStart = '0;
      end
      if (badE < 0 && int'(rampOut) != rExp(st, stp, lim, e)) begin
        badE = e; badAct = int'(rampOut); badExp = rExp(st, stp, lim, e);
      end
      if (peakDetect) begin
        pulses++;
        if (gotDet < 0) gotDet = e;
      end
    end
    chk(badE < 0, {rq, " ramp value (R4/R5)"}, badAct, badExp);
    chk(gotDet == expDet, "R6 detect edge", gotDet, expDet);
    chk(pulses == ((expDet < 0) ? 0 : 1), "R7 pulse count", pulses, (expDet < 0) ? 0 : 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int starts[3] = '{0, 40, 200};
    int steps[3]  = '{1, 7, 30};
    int smps[4]   = '{0, 50, 150, 255};
    rstN = 1'b0; rampEn = 1'b1; startSrcEn = 1'b1; endEn = 1'b0;
    frameStart = '0; frameSyncEn = 4'b0001; filtSel = 2'd0; feSel = 2'd2;
    filtOut = '0; feSample = '0; stepVal = '0; endVal = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(rampOut == 0, "R1 rampOut", int'(rampOut), 0);
    chk(!peakDetect, "R1 peakDetect", int'(peakDetect), 0);
    chk(!rampActive, "R1 rampActive", int'(rampActive), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rampOut == 0 && !rampActive, "R1 idle after reset", int'(rampOut), 0);

    // Main sweep, R4 R5 R6 R7: selected sample on FE2, others 0
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 2; d++) begin
            filtOut  = packF(starts[a], 17, 99);
            feSample = {TW'(smps[c]), TW'(0), TW'(0)};
            runFrame(0, starts[a], steps[b], smps[c], d[0], 120, 60, 0, 0, "sweep");
          end

    // R3: filter select including out-of-range
    feSample = {TW'(255), TW'(255), TW'(255)};
    for (int fs = 0; fs < 4; fs++) begin
      filtSel = 2'(fs);
      filtOut = packF(10, 20, 30);
      runFrame(0, (fs < 3) ? 10 * (fs + 1) : 0, 0, 255, 1'b0, 0, 3, 0, 0, "R3 filtSel");
    end
    // R3: start source disabled
    startSrcEn = 1'b0; filtSel = 2'd1;
    runFrame(0, 0, 5, 255, 1'b0, 0, 10, 0, 0, "R3 srcOff");
    startSrcEn = 1'b1; filtSel = 2'd0;

    // R6: front-end select; fe0=5, fe1=200, fe2=0; select 3 never detects
    feSample = {TW'(0), TW'(200), TW'(5)};
    filtOut = packF(0, 0, 0);
    feSel = 2'd0; runFrame(0, 0, 10, 5, 1'b0, 0, 40, 0, 0, "R6 fe0");
    feSel = 2'd1; runFrame(0, 0, 10, 200, 1'b0, 0, 100, 0, 0, "R6 fe1");
    feSel = 2'd3; runFrame(0, 0, 60, 255, 1'b0, 0, 40, 0, 0, "R6 feOut");
    feSel = 2'd2;

    // R2: masked channel mid-frame is ignored
    frameSyncEn = 4'b0100;
    feSample = {TW'(255), TW'(255), TW'(255)};
    filtOut = packF(3, 0, 0);
    runFrame(2, 3, 9, 255, 1'b0, 0, 20, 1, 1, "R2 stray");
    // R2: masked channel at saturation leaves ramp untouched
    runFrame(2, 3, 30, 255, 1'b1, 120, 40, 0, 0, "R2 sat");
    filtOut = packF(7, 0, 0);
    @(negedge clk); frameStart = 4'b0001;
    @(posedge clk); @(negedge clk); frameStart = '0;
    @(posedge clk); @(negedge clk);
    chk(rampOut == 120, "R2 masked frame start ignored", int'(rampOut), 120);

    // R9: filter change mid-frame does not alter ramp
    filtOut = packF(11, 0, 0);
    runFrame(2, 11, 4, 255, 1'b0, 0, 20, 2, 0, "R9 midframe");

    // R8: disable clears and ignores triggers
    @(negedge clk); rampEn = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rampOut == 0, "R8 cleared", int'(rampOut), 0);
    chk(!rampActive, "R8 inactive", int'(rampActive), 0);
    frameStart = 4'b0100; feSample = '0; filtOut = packF(90, 90, 90);
    @(posedge clk); @(negedge clk); frameStart = '0;
    @(posedge clk); @(negedge clk);
    chk(rampOut == 0 && !peakDetect, "R8 trigger ignored", int'(rampOut), 0);
    rampEn = 1'b1;

    // R7: re-arm on consecutive frames
    filtOut = packF(0, 0, 0);
    feSample = {TW'(50), TW'(0), TW'(0)};
    runFrame(2, 0, 20, 50, 1'b0, 0, 20, 0, 0, "R7 frameA");
    runFrame(2, 0, 20, 50, 1'b0, 0, 20, 0, 0, "R7 frameB");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule